// File: doc/BRIEF.md
# Parallel I/O Port Block with Direction Control

This block offers 24 general-purpose digital lines to a host through a byte-wide register bus. The lines form two full-width ports, A and B, and a third port, C. Port C is split into a low and a high nibble, and each nibble takes its own direction. Each line is modelled as three parts: an output latch (`pins_out`), an output enable (`pins_oe`) and an input sample (`pins_in`). The input sample passes through a two-flop synchronizer before the block reads it back or loads it into a latch.

Each of the four line groups has its own small state machine with three states:
- `GRP_IN_FRESH`: the group is an input and has never been written.
- `GRP_IN_HELD`: the group is an input and its latch holds a written or captured value.
- `GRP_OUT_DRIVE`: the group is an output.

The state machine takes these transitions:
- A data write moves a group from `GRP_IN_FRESH` to `GRP_IN_HELD`.
- An applied direction write that selects output moves a group from `GRP_IN_FRESH` to `GRP_OUT_DRIVE`. On this transition the group first copies its synchronized pin value into its latch, so the outputs do not glitch.
- An applied direction write that selects output moves a group from `GRP_IN_HELD` to `GRP_OUT_DRIVE`.
- An applied direction write that selects input moves a group from `GRP_OUT_DRIVE` to `GRP_IN_HELD`.

Only reset returns a group to `GRP_IN_FRESH`. A separate global control forces all 24 enables low, which tri-states every line.

A host writes data at any time, then switches groups to output by writing the direction register with its apply flag set. It reads the pins back through the same data offsets.

Top module: `pio24_core`

## Requirements
- R1: After reset every group is in input mode: `pins_oe` is all zero. The direction register reads 0x1B and the buffer register (offset 0xA) reads 0x00.
- R2: A write to offset 3 with bit 7 = 1 sets each group's direction: bit 4 controls A (lines 7:0), bit 1 controls B (lines 15:8), bit 0 controls C low (lines 19:16) and bit 3 controls C high (lines 23:20). A bit value of 1 means input and 0 means output. An output group drives `pins_oe` high on all its lines, unless the lines are disabled by R8.
- R3: A write to offset 3 with bit 7 = 0 is ignored: directions and `pins_oe` stay unchanged.
- R4: Reading offset 3 always returns 0 in bits 7, 6, 5 and 2.
- R5: Data writes to offset 0 (A), 1 (B) and 2 (C) are accepted while the group is an input. When the group later becomes an output, it drives the last written value.
- R6: A group never written since reset that is switched to output drives the value sampled on its pins at the moment of the switch.
- R7: Reading offsets 0, 1 and 2 returns the synchronized pin state (two clock cycles of latency), in both input and output mode.
- R8: Writing 1 to bit 0 of offset 0xA forces all of `pins_oe` to 0, and writing 0 restores it. Bit 0 of offset 0xA reads back the disable state.
- R9: A write to offset 2 updates both C nibbles and marks both nibbles as written.
- R10: A group that returns to input and is later switched to output again drives its latch value, not the pin value.
- R11: `pins_out` changes only in the clock cycle after a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pins_in | input | 24 | Sensed line levels |
| pins_out | output | 24 | Output latch values |
| pins_oe | output | 24 | Per-line output enable |

## Verification
The bench builds the block with its default parameters: a port width of 8 and a 4-bit offset. These defaults give two 4-bit C nibbles and the fixed 8-bit direction register layout. Every group-state transition can then be reached from host writes alone. The bench connects the pins in a loop: each line sees its own latch value while enabled and an external value otherwise. A read therefore shows both sides, and capture on the first output switch becomes observable.

// File: rtl/pio24_pkg.sv
package pio24_pkg;

    typedef enum logic [1:0] {
        GRP_IN_FRESH,
        GRP_IN_HELD,
        GRP_OUT_DRIVE
    } grp_state_t;

    localparam int NUM_GRP = 4;

    localparam logic [3:0] OFF_A   = 4'h0;
    localparam logic [3:0] OFF_B   = 4'h1;
    localparam logic [3:0] OFF_C   = 4'h2;
    localparam logic [3:0] OFF_DIR = 4'h3;
    localparam logic [3:0] OFF_BUF = 4'hA;

    // direction bit position decoded by software, per group A, B, C low, C high
    function automatic int dir_pos(input int g);
        case (g)
            0:       return 4;
            1:       return 1;
            2:       return 0;
            default: return 3;
        endcase
    endfunction

    function automatic int grp_width(input int g, input int pw);
        return (g < 2) ? pw : pw / 2;
    endfunction

    function automatic int grp_lsb(input int g, input int pw);
        case (g)
            0:       return 0;
            1:       return pw;
            2:       return 2 * pw;
            default: return 2 * pw + pw / 2;
        endcase
    endfunction

    // position of the group's slice inside the written byte
    function automatic int grp_boff(input int g, input int pw);
        return (g == 3) ? pw / 2 : 0;
    endfunction

endpackage

// File: rtl/pio24_sync.sv
module pio24_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pio24_group.sv
module pio24_group
    import pio24_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data,
    input  logic [W-1:0] wdata,
    input  logic         set_dir,
    input  logic         dir_in,
    input  logic [W-1:0] sample,
    output logic [W-1:0] lat,
    output logic         is_out
);
    grp_state_t state_q, state_d;
    logic       cap_pins;

    always_comb begin
        state_d  = state_q;
        cap_pins = 1'b0;
        unique case (state_q)
            GRP_IN_FRESH: begin
                if (wr_data) begin
                    state_d = GRP_IN_HELD;
                end else if (set_dir && !dir_in) begin
                    state_d  = GRP_OUT_DRIVE;
                    cap_pins = 1'b1;
                end
            end
            GRP_IN_HELD: begin
                if (set_dir && !dir_in) state_d = GRP_OUT_DRIVE;
            end
            GRP_OUT_DRIVE: begin
                if (set_dir && dir_in) state_d = GRP_IN_HELD;
            end
            default: state_d = GRP_IN_FRESH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GRP_IN_FRESH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lat <= '0;
        else if (wr_data)  lat <= wdata;
        else if (cap_pins) lat <= sample;
    end

    always_comb begin
        is_out = (state_q == GRP_OUT_DRIVE);
    end
endmodule

// File: rtl/pio24_core.sv
module pio24_core
    import pio24_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [PORT_W-1:0]     bus_wdata,
    output logic [PORT_W-1:0]     bus_rdata,
    input  logic [3*PORT_W-1:0]   pins_in,
    output logic [3*PORT_W-1:0]   pins_out,
    output logic [3*PORT_W-1:0]   pins_oe
);
    localparam int LINES   = 3 * PORT_W;
    localparam int SET_BIT = PORT_W - 1;

    logic [LINES-1:0]   pins_s;
    logic [NUM_GRP-1:0] grp_out;
    logic               dis_q;
    logic               dir_apply;
    logic [PORT_W-1:0]  dir_rd;

    pio24_sync #(.W(LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_in),
        .q     (pins_s)
    );

    assign dir_apply = bus_wr && (bus_addr == ADDR_W'(OFF_DIR)) && bus_wdata[SET_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dis_q <= 1'b0;
        else if (bus_wr && bus_addr == ADDR_W'(OFF_BUF)) dis_q <= bus_wdata[0];
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int GW  = grp_width(g, PORT_W);
        localparam int LSB = grp_lsb(g, PORT_W);
        localparam int BO  = grp_boff(g, PORT_W);
        localparam logic [3:0] OFF = (g == 0) ? OFF_A : (g == 1) ? OFF_B : OFF_C;

        logic [GW-1:0] lat;

        pio24_group #(.W(GW)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_data (bus_wr && bus_addr == ADDR_W'(OFF)),
            .wdata   (bus_wdata[BO +: GW]),
            .set_dir (dir_apply),
            .dir_in  (bus_wdata[dir_pos(g)]),
            .sample  (pins_s[LSB +: GW]),
            .lat     (lat),
            .is_out  (grp_out[g])
        );

        assign pins_out[LSB +: GW] = lat;
        assign pins_oe[LSB +: GW]  = {GW{grp_out[g] & ~dis_q}};
    end

    always_comb begin
        dir_rd = '0;
        for (int g = 0; g < NUM_GRP; g++) dir_rd[dir_pos(g)] = ~grp_out[g];
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFF_A):   bus_rdata = pins_s[0 +: PORT_W];
            ADDR_W'(OFF_B):   bus_rdata = pins_s[PORT_W +: PORT_W];
            ADDR_W'(OFF_C):   bus_rdata = pins_s[2*PORT_W +: PORT_W];
            ADDR_W'(OFF_DIR): bus_rdata = dir_rd;
            ADDR_W'(OFF_BUF): bus_rdata = {{(PORT_W-1){1'b0}}, dis_q};
            default:          bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pio24_chk.sv
module pio24_chk #(
    parameter int PORT_W = 8,
    parameter int ADDR_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [PORT_W-1:0]   bus_wdata,
    input logic [PORT_W-1:0]   bus_rdata,
    input logic [3*PORT_W-1:0] pins_out,
    input logic [3*PORT_W-1:0] pins_oe
);
    // R1
    reset_in_chk: assert property (@(posedge clk) !rst_n |=> pins_oe == '0);

    // R3
    noflag_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(3) && !bus_wdata[PORT_W-1] |=> $stable(pins_oe));

    // R4
    dir_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(3) |-> (bus_rdata[7:5] == 3'b000 && bus_rdata[2] == 1'b0));

    // R5
    datawr_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr <= ADDR_W'(2) |=> $stable(pins_oe));

    // R8
    dis_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(10) && bus_wdata[0] |=> pins_oe == '0);

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pins_out));
endmodule

bind pio24_core pio24_chk #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pins_out  (pins_out),
    .pins_oe   (pins_oe)
);

// File: tb/sim_pio24_core.sv
`timescale 1ns/1ps
module sim_pio24_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] pins_in, pins_out, pins_oe;
    logic [23:0] ext = 24'h5A3C96;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model state
    logic [23:0] m_lat = '0;
    logic [3:0]  m_out = '0;
    logic [3:0]  m_wr = '0;
    logic        m_dis = 1'b0;

    always #5 clk = ~clk;

    assign pins_in = (pins_oe & pins_out) | (~pins_oe & ext);

    pio24_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins_in),
        .pins_out(pins_out), .pins_oe(pins_oe)
    );

    function automatic logic [23:0] grp_mask(input int g);
        case (g)
            0:       return 24'h0000FF;
            1:       return 24'h00FF00;
            2:       return 24'h0F0000;
            default: return 24'hF00000;
        endcase
    endfunction

    function automatic int dpos(input int g);
        case (g) 0: return 4; 1: return 1; 2: return 0; default: return 3; endcase
    endfunction

    function automatic logic [23:0] exp_oe();
        logic [23:0] m = '0;
        for (int g = 0; g < 4; g++) if (m_out[g] && !m_dis) m = m | grp_mask(g);
        return m;
    endfunction

    function automatic logic [7:0] exp_dir();
        logic [7:0] d = '0;
        for (int g = 0; g < 4; g++) d[dpos(g)] = ~m_out[g];
        return d;
    endfunction

    function automatic logic [23:0] exp_pins();
        return (exp_oe() & m_lat) | (~exp_oe() & ext);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        // model update
        case (a)
            4'h0: begin m_lat[7:0] = d; m_wr[0] = 1'b1; end
            4'h1: begin m_lat[15:8] = d; m_wr[1] = 1'b1; end
            4'h2: begin m_lat[23:16] = d; m_wr[2] = 1'b1; m_wr[3] = 1'b1; end
            4'h3: if (d[7]) begin
                for (int g = 0; g < 4; g++) begin
                    if (!d[dpos(g)] && !m_out[g] && !m_wr[g])
                        m_lat = (m_lat & ~grp_mask(g)) | (ext & grp_mask(g));
                    if (!d[dpos(g)]) m_wr[g] = 1'b1;
                    m_out[g] = !d[dpos(g)];
                end
            end
            4'hA: m_dis = d[0];
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [7:0] r;
        logic [23:0] p;
        settle();
        check({req, " oe"}, pins_oe, exp_oe());
        check({req, " out"}, pins_out, m_lat);
        p = exp_pins();
        bus_read(4'h0, r); check({req, " rdA"}, r, p[7:0]);
        bus_read(4'h1, r); check({req, " rdB"}, r, p[15:8]);
        bus_read(4'h2, r); check({req, " rdC"}, r, p[23:16]);
        bus_read(4'h3, r); check({req, " rdDir"}, r, exp_dir());
        bus_read(4'hA, r); check({req, " rdBuf"}, r, {7'b0, m_dis});
    endtask

    initial begin
        logic [7:0] r;
        int unused;
        unused = $urandom(32'h1234ABCD);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_all("R1");
        // R5 data write while input, later driven
        bus_write(4'h2, 8'hC3);
        check_all("R5 held");
        bus_write(4'h3, 8'h9E); // C low output, C high input (bit3=1), A,B input
        check_all("R5 R9 C low drives written");
        // R6 fresh A switched: captures ext
        ext = 24'h11A7E2;
        settle();
        bus_write(4'h3, 8'h86); // A out (bit4=0), B in(bit1=1), C low out, C high out
        check_all("R6 fresh capture");
        // R3 no apply flag
        bus_write(4'h3, 8'h1B);
        check_all("R3 ignored");
        // R4 reserved bits with flag set
        bus_write(4'h3, 8'hFF);
        bus_read(4'h3, r);
        check("R4 reserved zero", {r[7:5], r[2]}, 4'b0);
        check_all("R2 all input");
        // R10 go back to output: latch, not pins
        ext = ~ext;
        settle();
        bus_write(4'h3, 8'h80);
        check_all("R10 relatch");
        // R8 disable / enable
        bus_write(4'hA, 8'h01);
        check_all("R8 disabled");
        bus_write(4'hA, 8'h00);
        check_all("R8 enabled");
        // R7 read while output sees latch; R11 random mix
        for (int i = 0; i < 150; i++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0: bus_write(4'($urandom_range(0, 2)), 8'($urandom));
                1: bus_write(4'h3, 8'($urandom) & 8'h9B);
                2: bus_write(4'h3, (8'($urandom) & 8'h1B) | 8'h80);
                3: bus_write(4'hA, 8'($urandom_range(0, 1)));
                default: begin ext = 24'($urandom); end
            endcase
            check_all("R7 R2 R11 random");
        end
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule